// File: doc/BRIEF.md
# Configuration Register Write Guard

This block holds the eight configuration and timing registers of a memory controller behind a simple peripheral bus (APB-style setup and access phases). It can lock them against accidental writes. Software turns the lock on or off by writing a guard-control word. That write takes effect only when the upper bits of the written word carry a fixed key. While the lock is on, a write aimed at any of the eight guarded registers is dropped. The dropped write leaves the register as it was. It also raises a violation flag and records the word offset it targeted.

Software finds the flag and the recorded offset in a status word. Reading that word returns its contents and then clears it. Reads of every register, and writes to the guard-control word, work the same whether the lock is on or off. The guarded register contents are driven out on a flat bus for the controller logic that uses them.

Top module: `wpu_top`

## Requirements
- R1: After reset the lock is off and the flag and source field are zero. Guarded register i (word offset i, i = 0..7) holds (i+1) * 0x01010101, and the control and status words read as zero.
- R2: The guard-control word sits at word offset 0x39. A write there loads bit 0 into the lock enable only when bits [31:8] of the written word equal 0xA5C3E1. Any other key value leaves the enable unchanged. A read returns the enable in bit 0 and zeros above it.
- R3: While the lock is on, a write to word offset 0..7 leaves that register's contents unchanged. This is visible both on read-back and on the configuration output bus.
- R4: A write dropped under R3 sets the violation flag, which is bit 0 of the status word, from the next cycle on.
- R5: The source field, status bits [23:8], holds the word offset of the most recent dropped write. A later violation overwrites it.
- R6: A read of the status word at offset 0x3A returns its current contents. After that read completes, the flag and the source field are zero.
- R7: While the lock is off, a write to offset 0..7 stores the written data. The value appears on read-back and on the configuration output bus from the next cycle, and no flag is raised.
- R8: Writes to the control word, to the status word and to unmapped offsets never raise the flag. Writes to the status word and to unmapped offsets change nothing, and reads of unmapped offsets return zero.
- R9: A transfer takes effect only in a cycle where both psel and penable are high. A setup phase alone, or penable without psel, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Word offset of the access |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| cfgOut | output | 256 | Guarded register contents, register i in bits [32i+31:32i] |

## Verification
The bench builds the block with its default parameters: eight guarded registers and an 8-bit word offset. With that setting the whole 256-entry address space is small enough to sweep. Every offset is written while the lock is on, and the status word, the target and the unmapped read value are checked after each write. Every guarded register is also written and read back with the lock off. Directed cases add a rejected key, back-to-back violations and bus phases that are not complete transfers.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

  localparam int NUM_PROT = 8;
  localparam int SRC_W    = 16;

  typedef struct packed {
    logic [NUM_PROT-1:0] regWe;
    logic                modeWe;
    logic                statRd;
    logic                viol;
    logic [SRC_W-1:0]    violSrc;
  } wpStrobe_t;

  function automatic logic [31:0] protResetVal(input int idx);
    return 32'(idx + 1) * 32'h0101_0101;
  endfunction

endpackage

// File: rtl/wpu_ctrl.sv
module wpu_ctrl
  import wpu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int MODE_OFF = 'h39,
  parameter int STAT_OFF = 'h3A,
  parameter logic [DATA_W-9:0] KEY = 24'hA5C3E1
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic              protEn,
  output wpStrobe_t         strb
);

  logic access;
  logic wrAcc;
  logic protHit;
  logic keyOk;

  assign access  = psel & penable;
  assign wrAcc   = access & pwrite;
  assign protHit = (paddr < ADDR_W'(NUM_PROT));
  assign keyOk   = (pwdata[DATA_W-1:8] == KEY);

  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_PROT; i++) begin
      strb.regWe[i] = wrAcc & ~protEn & (paddr == ADDR_W'(i));
    end
    strb.modeWe  = wrAcc & keyOk & (paddr == ADDR_W'(MODE_OFF));
    strb.statRd  = access & ~pwrite & (paddr == ADDR_W'(STAT_OFF));
    strb.viol    = wrAcc & protEn & protHit;
    strb.violSrc = SRC_W'(paddr);
  end

endmodule

// File: rtl/wpu_data.sv
module wpu_data
  import wpu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int MODE_OFF = 'h39,
  parameter int STAT_OFF = 'h3A
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  wpStrobe_t                  strb,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [DATA_W-1:0]          pwdata,
  output logic                       protEn,
  output logic                       violFlag,
  output logic [SRC_W-1:0]           violSrc,
  output logic [NUM_PROT*DATA_W-1:0] cfgOut,
  output logic [DATA_W-1:0]          prdata
);

  localparam int IDX_W = $clog2(NUM_PROT);

  logic [DATA_W-1:0] cfgReg [NUM_PROT];

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)              cfgReg[g] <= DATA_W'(protResetVal(g));
      else if (strb.regWe[g]) cfgReg[g] <= pwdata;
    end
    assign cfgOut[g*DATA_W +: DATA_W] = cfgReg[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            protEn <= 1'b0;
    else if (strb.modeWe) protEn <= pwdata[0];
  end

  // A fresh violation takes priority over the clear-on-read.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      violFlag <= 1'b0;
      violSrc  <= '0;
    end else if (strb.viol) begin
      violFlag <= 1'b1;
      violSrc  <= strb.violSrc;
    end else if (strb.statRd) begin
      violFlag <= 1'b0;
      violSrc  <= '0;
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr < ADDR_W'(NUM_PROT))
      prdata = cfgReg[paddr[IDX_W-1:0]];
    else if (paddr == ADDR_W'(MODE_OFF))
      prdata = DATA_W'(protEn);
    else if (paddr == ADDR_W'(STAT_OFF))
      prdata = DATA_W'({violSrc, 7'b0, violFlag});
  end

endmodule

// File: rtl/wpu_top.sv
module wpu_top
  import wpu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int MODE_OFF = 'h39,
  parameter int STAT_OFF = 'h3A,
  parameter logic [DATA_W-9:0] KEY = 24'hA5C3E1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [DATA_W-1:0]          pwdata,
  output logic [DATA_W-1:0]          prdata,
  output logic [NUM_PROT*DATA_W-1:0] cfgOut
);

  wpStrobe_t        strb;
  logic             protEn;
  logic             violFlag;
  logic [SRC_W-1:0] violSrc;

  wpu_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MODE_OFF(MODE_OFF), .STAT_OFF(STAT_OFF), .KEY(KEY)
  ) i_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .protEn(protEn), .strb(strb)
  );

  wpu_data #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MODE_OFF(MODE_OFF), .STAT_OFF(STAT_OFF)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .paddr(paddr), .pwdata(pwdata),
    .protEn(protEn), .violFlag(violFlag), .violSrc(violSrc),
    .cfgOut(cfgOut), .prdata(prdata)
  );

endmodule

// File: rtl/wpu_chk.sv
module wpu_chk
  import wpu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int MODE_OFF = 'h39,
  parameter int STAT_OFF = 'h3A,
  parameter logic [DATA_W-9:0] KEY = 24'hA5C3E1
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       psel,
  input logic                       penable,
  input logic                       pwrite,
  input logic [ADDR_W-1:0]          paddr,
  input logic [DATA_W-1:0]          pwdata,
  input logic [NUM_PROT*DATA_W-1:0] cfgOut,
  input logic                       protEn,
  input logic                       violFlag,
  input logic [SRC_W-1:0]           violSrc
);

  logic wrAcc, rdStat, guardedHit;
  assign wrAcc      = psel && penable && pwrite;
  assign rdStat     = psel && penable && !pwrite && (paddr == ADDR_W'(STAT_OFF));
  assign guardedHit = (paddr < ADDR_W'(NUM_PROT));

  p_blocked_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && protEn && guardedHit) |=> $stable(cfgOut));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && protEn && guardedHit) |=> violFlag);

  p_src_latch_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && protEn && guardedHit) |=> (violSrc == SRC_W'($past(paddr))));

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdStat |=> (!violFlag && violSrc == '0));

  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && paddr == ADDR_W'(MODE_OFF) && pwdata[DATA_W-1:8] != KEY) |=> $stable(protEn));

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_open
    p_open_write_r7: assert property (@(posedge clk) disable iff (!rstN)
      (wrAcc && !protEn && paddr == ADDR_W'(g))
        |=> (cfgOut[g*DATA_W +: DATA_W] == $past(pwdata)));
  end

endmodule

bind wpu_top wpu_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .MODE_OFF(MODE_OFF), .STAT_OFF(STAT_OFF), .KEY(KEY)
) u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .cfgOut(cfgOut),
  .protEn(protEn), .violFlag(violFlag), .violSrc(violSrc)
);

// File: tb/test_wpu_top.sv
module test_wpu_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MODE_A = 8'h39;
  localparam logic [7:0] STAT_A = 8'h3A;
  localparam logic [23:0] GOOD_KEY = 24'hA5C3E1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [255:0] cfgOut;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  wpu_top i_wpu_top (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cfgOut(cfgOut)
  );

  function automatic logic [31:0] defVal(input int i);
    return 32'(i + 1) * 32'h0101_0101;
  endfunction

  function automatic logic [31:0] statWord(input logic [15:0] src, input logic flag);
    return {8'h00, src, 7'h00, flag};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic checkRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
    check(tag, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = defVal(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      check("R1 cfgOut", cfgOut[i*32 +: 32], defVal(i));
      checkRead(8'(i), defVal(i), "R1 readback");
    end
    checkRead(MODE_A, 32'h0, "R1 mode");
    checkRead(STAT_A, 32'h0, "R1 status");

    // R7: lock off, writes land
    for (int i = 0; i < 8; i++) begin
      model[i] = 32'hC000_0000 ^ (32'(i) * 32'h0001_0203);
      apbWrite(8'(i), model[i]);
      check("R7 cfgOut", cfgOut[i*32 +: 32], model[i]);
      checkRead(8'(i), model[i], "R7 readback");
      checkRead(STAT_A, 32'h0, "R7 no flag");
    end

    // R2: key gating
    apbWrite(MODE_A, {24'h123456, 8'h01});
    checkRead(MODE_A, 32'h0, "R2 bad key");
    apbWrite(MODE_A, {GOOD_KEY, 8'h01});
    checkRead(MODE_A, 32'h1, "R2 good key");

    // R3/R4/R5/R6/R8: full address sweep with lock on
    for (int a = 0; a < 256; a++) begin
      apbWrite(8'(a), 32'h5A5A_0000 | 32'(a));
      if (a < 8) begin
        check("R3 cfgOut", cfgOut[a*32 +: 32], model[a]);
        checkRead(STAT_A, statWord(16'(a), 1'b1), "R4 R5 status");
        checkRead(STAT_A, 32'h0, "R6 cleared");
        checkRead(8'(a), model[a], "R3 readback");
      end else begin
        checkRead(STAT_A, 32'h0, "R8 no flag");
        if (8'(a) == MODE_A)
          checkRead(MODE_A, 32'h1, "R2 sweep bad key");
        else if (8'(a) != STAT_A)
          checkRead(8'(a), 32'h0, "R8 unmapped read");
      end
    end

    // R5: overwrite by later violation
    apbWrite(8'd3, 32'hDEAD_0003);
    apbWrite(8'd6, 32'hDEAD_0006);
    checkRead(STAT_A, statWord(16'd6, 1'b1), "R5 overwrite");
    checkRead(STAT_A, 32'h0, "R6 second read");

    // R9: incomplete bus phases, lock off
    apbWrite(MODE_A, {GOOD_KEY, 8'h00});
    checkRead(MODE_A, 32'h0, "R2 disable");
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 8'd0; pwdata = 32'hFFFF_FFFF;
    @(negedge clk); psel = 0; penable = 1;
    @(negedge clk); penable = 0; pwrite = 0;
    check("R9 cfgOut", cfgOut[31:0], model[0]);
    checkRead(8'd0, model[0], "R9 readback");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule